// File: doc/BRIEF.md
# Drum Channel Command Sequencer

This block is a small channel processor that runs a chained drum program held in main memory. A program counter for the channel lives at a fixed memory location. Each command fetch reads that counter, reads the command word it points to, and writes back the counter: the next address, or the branch target when the command is a branch. Transfer commands are followed by two more words. One carries the direction and the core address, the other carries the drum address. Words then move one at a time between the memory port and the drum storage port.

Word timing comes from a `word_tick` input, which marks one drum word time. Each word waits one tick. A word that starts a new sector waits for the inter-sector gap instead. A 12-bit folded checksum accumulates over the words of each transfer. End commands stop the channel and may raise an interrupt. Software starts the channel, clears it, and tests it through the `busy` and `err_flag` status outputs.

Top module: `drum_cmd_seq`

## Requirements
- R1: After reset or `clr`, `busy`, `irq`, `err_flag` and `parity` are 0 and neither `mem_req` nor `drm_req` is asserted until the next accepted `start`.
- R2: `start` while idle raises `busy` on the next cycle. Each command-word fetch reads the counter at memory address 8, reads the word it points to, and writes the counter plus one back to address 8. `start` while `busy` is high has no effect.
- R3: The opcode sits in bits 23:21 of a command word. Code 0 is a transfer: its bits 13:0 give the word count, and it is followed by a core word (bit 23 = 1 means memory-to-drum, bits 13:0 are the core address) and a drum word (bits 20:0: track 20:14, sector 13:11, word 10:0).
- R4: In memory-to-drum mode, each word is read from memory at the core address and written to the drum at the drum address. Both addresses then increment and the count decrements. At count zero the channel fetches its next command.
- R5: In drum-to-memory mode, each word is read from the drum and written to memory at the core address, with the same address and count stepping as R4.
- R6: A word waits one `word_tick`. When the drum address after a word has word field 0, the next word waits 236 ticks.
- R7: The drum address wraps from 84*8*2048-1 to 0.
- R8: `parity` is cleared when a drum word is fetched. For each word moved, it XORs in bits 23:12, rotates the 12-bit value left by one, then XORs in bits 11:0.
- R9: Code 2 is a branch: its bits 13:0 are written to the counter location instead of the incremented counter.
- R10: Code 4 ends the program without an interrupt. Code 5 ends it and raises `irq` only if the error flag is set. Code 7 ends it and always raises `irq`. `busy` falls when the program ends.
- R11: A drum access acknowledged with `drm_fault` sets `err_flag`. Code 3 clears the error flag and fetching continues. Code 1 acts as code 0 when the flag is clear; when the flag is set it raises `irq` and ends the program.
- R12: `clr` stops a running program at once and clears a pending `irq` and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start the channel program (idle only) |
| clr | input | 1 | Synchronous channel clear |
| word_tick | input | 1 | One pulse per drum word time |
| busy | output | 1 | Program running |
| irq | output | 1 | Pending drum interrupt |
| err_flag | output | 1 | Channel error flag |
| parity | output | 12 | Folded checksum of the current transfer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Memory address |
| mem_wdata | output | 24 | Memory write data |
| mem_ack | input | 1 | Memory single-cycle acknowledge |
| mem_rdata | input | 24 | Memory read data, valid with ack |
| drm_req | output | 1 | Drum access request |
| drm_we | output | 1 | Drum write enable |
| drm_addr | output | 21 | Drum word address |
| drm_wdata | output | 24 | Drum write data |
| drm_ack | input | 1 | Drum single-cycle acknowledge |
| drm_rdata | input | 24 | Drum read data, valid with ack |
| drm_fault | input | 1 | Drum error, sampled with ack |

## Verification
A wrong fetch phase or command decode shows up within one command as a counter value written back to address 8 that differs from the expected one, or as an access to an address the program never named. A wrong gap counter is exposed on the next drum access, because the number of word ticks between two accesses is counted against 1 or 236. Errors in address stepping, wrap or checksum appear on the next word as a mismatched drum or memory write, or as a `parity` value that differs once the transfer ends.

// File: rtl/drum_seq_pkg.sv
`timescale 1ns/1ps
package drum_seq_pkg;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_CORE,
        PH_DRUM,
        PH_XFER
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAT,
        ST_RD_PC,
        ST_RD_WORD,
        ST_WR_PC,
        ST_TICK,
        ST_ACC1,
        ST_ACC2
    } step_e;

    localparam logic [2:0] OP_XFER   = 3'd0;
    localparam logic [2:0] OP_CXFER  = 3'd1;
    localparam logic [2:0] OP_BRANCH = 3'd2;
    localparam logic [2:0] OP_CLRERR = 3'd3;
    localparam logic [2:0] OP_END    = 3'd4;
    localparam logic [2:0] OP_END_IE = 3'd5;
    localparam logic [2:0] OP_END_IU = 3'd7;

endpackage

// File: rtl/drum_gap_timer.sv
`timescale 1ns/1ps
module drum_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kill)
            cnt_d = '0;
        else if (load)
            cnt_d = load_val;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = tick && (cnt_q == CNT_W'(1)) && !load && !kill;
endmodule

// File: rtl/drum_addr_next.sv
`timescale 1ns/1ps
module drum_addr_next #(
    parameter int WORD_BITS  = 11,
    parameter int DA_W       = 21,
    parameter int DRUM_WORDS = 84 * 8 * 2048
) (
    input  logic [DA_W-1:0] da,
    output logic [DA_W-1:0] da_next,
    output logic            sect_start
);
    logic [DA_W:0] inc;

    assign inc        = {1'b0, da} + 1'b1;
    assign da_next    = (inc >= (DA_W+1)'(DRUM_WORDS)) ? '0 : inc[DA_W-1:0];
    assign sect_start = (da_next[WORD_BITS-1:0] == '0);
endmodule

// File: rtl/drum_parity_fold.sv
`timescale 1ns/1ps
module drum_parity_fold #(
    parameter int HALF = 12
) (
    input  logic [HALF-1:0]   par_in,
    input  logic [2*HALF-1:0] word,
    output logic [HALF-1:0]   par_out
);
    logic [HALF-1:0] mix;

    assign mix     = par_in ^ word[2*HALF-1:HALF];
    assign par_out = {mix[HALF-2:0], mix[HALF-1]} ^ word[HALF-1:0];
endmodule

// File: rtl/drum_cmd_seq.sv
`timescale 1ns/1ps
module drum_cmd_seq
    import drum_seq_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 24,
    parameter int WC_W       = 14,
    parameter int WORD_BITS  = 11,
    parameter int SECT_BITS  = 3,
    parameter int TRACK_BITS = 7,
    parameter int NUM_TRACKS = 84,
    parameter int GAP_WORDS  = 236,
    parameter int FETCH_LAT  = 3,
    parameter int PC_LOC     = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic                                   clr,
    input  logic                                   word_tick,
    output logic                                   busy,
    output logic                                   irq,
    output logic                                   err_flag,
    output logic [DATA_W/2-1:0]                    parity,
    output logic                                   mem_req,
    output logic                                   mem_we,
    output logic [ADDR_W-1:0]                      mem_addr,
    output logic [DATA_W-1:0]                      mem_wdata,
    input  logic                                   mem_ack,
    input  logic [DATA_W-1:0]                      mem_rdata,
    output logic                                   drm_req,
    output logic                                   drm_we,
    output logic [WORD_BITS+SECT_BITS+TRACK_BITS-1:0] drm_addr,
    output logic [DATA_W-1:0]                      drm_wdata,
    input  logic                                   drm_ack,
    input  logic [DATA_W-1:0]                      drm_rdata,
    input  logic                                   drm_fault
);
    localparam int DA_W       = WORD_BITS + SECT_BITS + TRACK_BITS;
    localparam int DRUM_WORDS = NUM_TRACKS * (1 << (WORD_BITS + SECT_BITS));
    localparam int HALF       = DATA_W / 2;
    localparam int GAP_W      = $clog2(GAP_WORDS + 1);
    localparam int LAT_W      = $clog2(FETCH_LAT + 1);

    typedef struct packed {
        phase_e            phase;
        step_e             step;
        logic [LAT_W-1:0]  lat;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] data;
        logic [WC_W-1:0]   wc;
        logic [ADDR_W-1:0] ca;
        logic [DA_W-1:0]   da;
        logic              rw;
        logic              err;
        logic              irq;
        logic              busy;
        logic [HALF-1:0]   par;
    } regs_t;

    regs_t q, n;

    logic             tmr_load;
    logic [GAP_W-1:0] tmr_val;
    logic             tmr_expire;
    logic [DA_W-1:0]  da_nxt;
    logic             sect_start;
    logic [HALF-1:0]  par_nxt;
    logic [2:0]       op_q;
    logic [2:0]       op_rd;

    drum_gap_timer #(.CNT_W(GAP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (clr),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (word_tick),
        .expire   (tmr_expire)
    );

    drum_addr_next #(.WORD_BITS(WORD_BITS), .DA_W(DA_W), .DRUM_WORDS(DRUM_WORDS)) u_anext (
        .da         (q.da),
        .da_next    (da_nxt),
        .sect_start (sect_start)
    );

    drum_parity_fold #(.HALF(HALF)) u_par (
        .par_in  (q.par),
        .word    (q.data),
        .par_out (par_nxt)
    );

    assign op_q  = q.word[DATA_W-1 -: 3];
    assign op_rd = mem_rdata[DATA_W-1 -: 3];

    // Port drive from registered state only
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ca;
        mem_wdata = q.data;
        drm_req   = 1'b0;
        drm_we    = 1'b0;
        drm_addr  = q.da;
        drm_wdata = q.data;
        unique case (q.step)
            ST_RD_PC: begin
                mem_req  = 1'b1;
                mem_addr = ADDR_W'(PC_LOC);
            end
            ST_RD_WORD: begin
                mem_req  = 1'b1;
                mem_addr = q.pc;
            end
            ST_WR_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ADDR_W'(PC_LOC);
                mem_wdata = DATA_W'(q.pc);
            end
            ST_ACC1: begin
                if (q.rw) mem_req = 1'b1;
                else      drm_req = 1'b1;
            end
            ST_ACC2: begin
                if (q.rw) begin
                    drm_req = 1'b1;
                    drm_we  = 1'b1;
                end else begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        n        = q;
        tmr_load = 1'b0;
        tmr_val  = GAP_W'(1);
        unique case (q.step)
            ST_IDLE: begin
                if (start) begin
                    n.busy  = 1'b1;
                    n.phase = PH_CMD;
                    n.step  = ST_LAT;
                    n.lat   = '0;
                end
            end
            ST_LAT: begin
                if (q.lat == LAT_W'(FETCH_LAT - 1)) begin
                    n.lat  = '0;
                    n.step = ST_RD_PC;
                end else begin
                    n.lat = q.lat + 1'b1;
                end
            end
            ST_RD_PC: begin
                if (mem_ack) begin
                    n.pc   = mem_rdata[ADDR_W-1:0];
                    n.step = ST_RD_WORD;
                end
            end
            ST_RD_WORD: begin
                if (mem_ack) begin
                    n.word = mem_rdata;
                    if (q.phase == PH_CMD && op_rd == OP_BRANCH)
                        n.pc = mem_rdata[ADDR_W-1:0];
                    else
                        n.pc = q.pc + 1'b1;
                    n.step = ST_WR_PC;
                end
            end
            ST_WR_PC: begin
                if (mem_ack) begin
                    n.step = ST_LAT;
                    unique case (q.phase)
                        PH_CMD: begin
                            unique case (op_q)
                                OP_XFER: begin
                                    n.wc    = q.word[WC_W-1:0];
                                    n.phase = PH_CORE;
                                end
                                OP_CXFER: begin
                                    if (q.err) begin
                                        n.irq  = 1'b1;
                                        n.busy = 1'b0;
                                        n.step = ST_IDLE;
                                    end else begin
                                        n.wc    = q.word[WC_W-1:0];
                                        n.phase = PH_CORE;
                                    end
                                end
                                OP_CLRERR: n.err = 1'b0;
                                OP_END: begin
                                    n.busy = 1'b0;
                                    n.step = ST_IDLE;
                                end
                                OP_END_IE: begin
                                    n.irq  = q.irq | q.err;
                                    n.busy = 1'b0;
                                    n.step = ST_IDLE;
                                end
                                OP_END_IU: begin
                                    n.irq  = 1'b1;
                                    n.busy = 1'b0;
                                    n.step = ST_IDLE;
                                end
                                default: ;
                            endcase
                        end
                        PH_CORE: begin
                            n.rw    = q.word[DATA_W-1];
                            n.ca    = q.word[ADDR_W-1:0];
                            n.phase = PH_DRUM;
                        end
                        PH_DRUM: begin
                            n.da     = q.word[DA_W-1:0];
                            n.par    = '0;
                            n.phase  = PH_XFER;
                            n.step   = ST_TICK;
                            tmr_load = 1'b1;
                            tmr_val  = GAP_W'(1);
                        end
                        default: ;
                    endcase
                end
            end
            ST_TICK: begin
                if (tmr_expire) n.step = ST_ACC1;
            end
            ST_ACC1: begin
                if (q.rw && mem_ack) begin
                    n.data = mem_rdata;
                    n.step = ST_ACC2;
                end else if (!q.rw && drm_ack) begin
                    n.data = drm_rdata;
                    if (drm_fault) n.err = 1'b1;
                    n.step = ST_ACC2;
                end
            end
            ST_ACC2: begin
                if ((q.rw && drm_ack) || (!q.rw && mem_ack)) begin
                    if (q.rw && drm_fault) n.err = 1'b1;
                    n.par = par_nxt;
                    n.da  = da_nxt;
                    n.ca  = q.ca + 1'b1;
                    n.wc  = q.wc - 1'b1;
                    if (q.wc == WC_W'(1)) begin
                        n.phase = PH_CMD;
                        n.step  = ST_LAT;
                        n.lat   = '0;
                    end else begin
                        n.step   = ST_TICK;
                        tmr_load = 1'b1;
                        tmr_val  = sect_start ? GAP_W'(GAP_WORDS) : GAP_W'(1);
                    end
                end
            end
            default: ;
        endcase

        if (clr) begin
            n       = '0;
            n.phase = PH_CMD;
            n.step  = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_CMD;
            q.step  <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign busy     = q.busy;
    assign irq      = q.irq;
    assign err_flag = q.err;
    assign parity   = q.par;
endmodule

// File: rtl/drum_cmd_seq_chk.sv
`timescale 1ns/1ps
module drum_cmd_seq_chk #(
    parameter int ADDR_W     = 14,
    parameter int DA_W       = 21,
    parameter int DRUM_WORDS = 84 * 8 * 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              clr,
    input logic              busy,
    input logic              irq,
    input logic              err_flag,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              drm_req,
    input logic [DA_W-1:0]   drm_addr,
    input logic              drm_ack,
    input logic              drm_fault
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !drm_req)); // R1

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !clr) |=> busy); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !clr) |=> (mem_req && $stable(mem_addr))); // R2

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && drm_req)); // R4

    AST_DRM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        drm_req |-> ({1'b0, drm_addr} < (DA_W+1)'(DRUM_WORDS))); // R7

    AST_IRQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy); // R10

    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(drm_ack && drm_fault)); // R11

    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!irq && !busy && !err_flag)); // R12
endmodule

bind drum_cmd_seq drum_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .clr       (clr),
    .busy      (busy),
    .irq       (irq),
    .err_flag  (err_flag),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .drm_req   (drm_req),
    .drm_addr  (drm_addr),
    .drm_ack   (drm_ack),
    .drm_fault (drm_fault)
);

// File: tb/drum_cmd_seq_bench.sv
`timescale 1ns/1ps
module drum_cmd_seq_bench;
    localparam int AW     = 14;
    localparam int DW     = 24;
    localparam int DAW    = 21;
    localparam int GAP    = 236;
    localparam int NWORDS = 84 * 8 * 2048;
    localparam int PCLOC  = 8;

    typedef struct {
        int          addr;
        logic [23:0] data;
        int          gap;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start, clr, word_tick;
    logic busy, irq, err_flag;
    logic [11:0] parity;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic drm_req, drm_we, drm_ack, drm_fault;
    logic [DAW-1:0] drm_addr;
    logic [DW-1:0] drm_wdata, drm_rdata;

    drum_cmd_seq u_drum_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .word_tick(word_tick),
        .busy(busy), .irq(irq), .err_flag(err_flag), .parity(parity),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .drm_req(drm_req), .drm_we(drm_we), .drm_addr(drm_addr), .drm_wdata(drm_wdata),
        .drm_ack(drm_ack), .drm_rdata(drm_rdata), .drm_fault(drm_fault)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit ignore_xfer = 0;
    int fault_addr = -1;
    longint tick_cnt = 0;
    longint last_acc_tick = 0;

    logic [DW-1:0] mem  [int];
    logic [DW-1:0] drum [int];
    item_t exp_drm[$];
    item_t exp_mem[$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] fold(input logic [11:0] p, input logic [23:0] w);
        logic [11:0] t;
        t = p ^ w[23:12];
        t = {t[10:0], t[11]};
        return t ^ w[11:0];
    endfunction

    function automatic logic [23:0] cmd(input int op, input int low);
        return {op[2:0], 21'(low)};
    endfunction

    function automatic logic [23:0] core(input bit to_drum, input int ca);
        return {to_drum, 9'd0, 14'(ca)};
    endfunction

    // Word-time source
    initial begin
        word_tick = 1'b0;
        forever begin
            repeat (7) @(negedge clk);
            word_tick = 1'b1;
            @(negedge clk);
            word_tick = 1'b0;
        end
    end

    // Memory model and monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[int'(mem_addr)] = mem_wdata;
                if (int'(mem_addr) != PCLOC && !ignore_xfer) begin
                    if (exp_mem.size() == 0) begin
                        check(0, "R5 unexpected memory write", mem_addr, 0);
                    end else begin
                        item_t e;
                        e = exp_mem.pop_front();
                        check(int'(mem_addr) == e.addr, {e.tag, " mem addr"}, mem_addr, e.addr);
                        check(mem_wdata == e.data, {e.tag, " mem data"}, mem_wdata, e.data);
                    end
                end
            end else begin
                mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Drum model and monitor
    always @(posedge clk) begin
        if (word_tick) tick_cnt++;
        if (!rst_n) begin
            drm_ack   <= 1'b0;
            drm_fault <= 1'b0;
        end else if (drm_req && !drm_ack) begin
            longint gap;
            gap = tick_cnt - last_acc_tick;
            last_acc_tick = tick_cnt;
            drm_ack   <= 1'b1;
            drm_fault <= (int'(drm_addr) == fault_addr);
            if (drm_we) begin
                drum[int'(drm_addr)] = drm_wdata;
                if (!ignore_xfer) begin
                    if (exp_drm.size() == 0) begin
                        check(0, "R4 unexpected drum write", drm_addr, 0);
                    end else begin
                        item_t e;
                        e = exp_drm.pop_front();
                        check(int'(drm_addr) == e.addr, {e.tag, " drum addr"}, drm_addr, e.addr);
                        check(drm_wdata == e.data, {e.tag, " drum data"}, drm_wdata, e.data);
                        if (e.gap >= 0)
                            check(gap == longint'(e.gap), "R6 word ticks between accesses", gap, e.gap);
                    end
                end
            end else begin
                drm_rdata <= drum.exists(int'(drm_addr)) ? drum[int'(drm_addr)] : '0;
            end
        end else begin
            drm_ack   <= 1'b0;
            drm_fault <= 1'b0;
        end
    end

    task automatic push_drm(input int a, input logic [23:0] d, input int g, input string t);
        item_t e;
        e.addr = a; e.data = d; e.gap = g; e.tag = t;
        exp_drm.push_back(e);
    endtask

    task automatic push_mem(input int a, input logic [23:0] d, input string t);
        item_t e;
        e.addr = a; e.data = d; e.gap = -1; e.tag = t;
        exp_mem.push_back(e);
    endtask

    task automatic pulse_start(input int pc);
        mem[PCLOC] = 24'(pc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [11:0] p;
        int da;
        rst_n = 1'b0; start = 1'b0; clr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && irq == 0 && err_flag == 0, "R1 status after reset", {busy, irq, err_flag}, 0);
        check(parity == 0, "R1 parity after reset", parity, 0);
        check(mem_req == 0 && drm_req == 0, "R1 no requests after reset", {mem_req, drm_req}, 0);

        // R3 R4 R6: memory-to-drum, crossing a sector; R2 start ignored while busy
        da = (1 << 14) | (2 << 11) | 2046;
        mem[32'h40] = cmd(0, 3);
        mem[32'h41] = core(1, 'h100);
        mem[32'h42] = 24'(da);
        mem[32'h43] = cmd(4, 0);
        mem['h100] = 24'h123456; mem['h101] = 24'hABCDEF; mem['h102] = 24'h0F0F0F;
        push_drm(da,     24'h123456, -1,  "R4");
        push_drm(da + 1, 24'hABCDEF, 1,   "R4");
        push_drm(da + 2, 24'h0F0F0F, GAP, "R6");
        pulse_start('h40);
        repeat (150) @(negedge clk);
        check(busy == 1, "R2 busy mid transfer", busy, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(mem[PCLOC] == 24'h44, "R2 counter after program", mem[PCLOC], 'h44);
        check(irq == 0, "R10 plain end raises no irq", irq, 0);
        p = fold(fold(fold(12'h0, 24'h123456), 24'hABCDEF), 24'h0F0F0F);
        check(parity == p, "R8 parity after write transfer", parity, p);

        // R5 R8 R10: drum-to-memory then end with unconditional irq
        da = (3 << 14) | (5 << 11) | 10;
        drum[da] = 24'hFEDCBA; drum[da + 1] = 24'h000FFF;
        mem['h50] = cmd(0, 2);
        mem['h51] = core(0, 'h200);
        mem['h52] = 24'(da);
        mem['h53] = cmd(7, 0);
        push_mem('h200, 24'hFEDCBA, "R5");
        push_mem('h201, 24'h000FFF, "R5");
        pulse_start('h50);
        wait_idle();
        check(irq == 1, "R10 unconditional end irq", irq, 1);
        p = fold(fold(12'h0, 24'hFEDCBA), 24'h000FFF);
        check(parity == p, "R8 parity after read transfer", parity, p);
        check(mem[PCLOC] == 24'h54, "R2 counter after read program", mem[PCLOC], 'h54);
        pulse_clr();
        check(irq == 0, "R12 clr drops irq", irq, 0);

        // R9 R7: branch, then transfer across the drum end
        mem['h60] = cmd(2, 'h80);
        mem['h80] = cmd(0, 2);
        mem['h81] = core(1, 'h300);
        mem['h82] = 24'(NWORDS - 1);
        mem['h83] = cmd(5, 0);
        mem['h300] = 24'h111111; mem['h301] = 24'h222222;
        push_drm(NWORDS - 1, 24'h111111, -1, "R7");
        push_drm(0, 24'h222222, GAP, "R7");
        pulse_start('h60);
        wait_idle();
        check(mem[PCLOC] == 24'h84, "R9 counter after branch", mem[PCLOC], 'h84);
        check(irq == 0, "R10 end-if-error without error", irq, 0);

        // R11: conditional transfer, fault, then conditional transfer stops
        fault_addr = 'h500;
        mem['hA0] = cmd(1, 1);
        mem['hA1] = core(1, 'h400);
        mem['hA2] = 24'h000500;
        mem['hA3] = cmd(1, 1);
        mem['h400] = 24'h5A5A5A;
        push_drm('h500, 24'h5A5A5A, -1, "R11");
        pulse_start('hA0);
        wait_idle();
        check(err_flag == 1, "R11 fault sets error", err_flag, 1);
        check(irq == 1, "R11 cond transfer with error irq", irq, 1);
        check(mem[PCLOC] == 24'hA4, "R11 stop after cond transfer", mem[PCLOC], 'hA4);
        pulse_clr();
        check(err_flag == 0 && irq == 0, "R12 clr clears error and irq", {err_flag, irq}, 0);

        // R10: end-if-error with error set
        mem['hC0] = cmd(0, 1);
        mem['hC1] = core(1, 'h400);
        mem['hC2] = 24'h000500;
        mem['hC3] = cmd(5, 0);
        push_drm('h500, 24'h5A5A5A, -1, "R10");
        pulse_start('hC0);
        wait_idle();
        check(irq == 1, "R10 end-if-error with error", irq, 1);

        // R12: clr in mid gap with irq pending
        ignore_xfer = 1;
        mem['hF0] = cmd(0, 2);
        mem['hF1] = core(1, 'h410);
        mem['hF2] = 24'h0007FF;
        mem['hF3] = cmd(7, 0);
        pulse_start('hF0);
        repeat (300) @(negedge clk);
        pulse_clr();
        check(busy == 0 && irq == 0 && err_flag == 0, "R12 clr stops channel", {busy, irq, err_flag}, 0);
        repeat (60) @(negedge clk);
        check(mem_req == 0 && drm_req == 0, "R1 quiet after clr", {mem_req, drm_req}, 0);
        check(mem[PCLOC] == 24'hF3, "R12 no fetch after clr", mem[PCLOC], 'hF3);
        ignore_xfer = 0;

        // R11: reset-error command clears the flag
        mem['hE0] = cmd(0, 1);
        mem['hE1] = core(1, 'h400);
        mem['hE2] = 24'h000500;
        mem['hE3] = cmd(3, 0);
        mem['hE4] = cmd(5, 0);
        push_drm('h500, 24'h5A5A5A, -1, "R11");
        pulse_start('hE0);
        wait_idle();
        check(err_flag == 0, "R11 reset-error command", err_flag, 0);
        check(irq == 0, "R11 no irq after error cleared", irq, 0);

        check(exp_drm.size() == 0, "R4 all drum writes seen", exp_drm.size(), 0);
        check(exp_mem.size() == 0, "R5 all memory writes seen", exp_mem.size(), 0);
        done = 1;
        finish_run();
    end
endmodule